// File: doc/BRIEF.md
# Snooping Coherence Controller for a Direct-Mapped Cache

This block manages a small direct-mapped cache that belongs to one core on a shared bus. Each line holds one data word, an address tag and a two-bit coherence tag with four values: Invalid, Shared, Exclusive and Modified. The local processor presents one load or store at a time. The controller answers hits from the line store. On a miss it fills the line over the bus. Before a store to a shared line completes, it broadcasts an invalidate. Before a dirty line is replaced, it writes the old contents back. A line filled by a load is always installed as Exclusive, with no check of other caches. The line drops to Shared only when another cache's load to it is later observed on the bus.

The controller examines every bus transaction issued by other caches, in the same cycle it appears. Observed loads downgrade the line. Observed invalidates and loads-for-ownership kill the line. When a dirty line is hit by either of these, the controller drives the line's data onto a flush port in that same cycle, before the line changes state. Observed writebacks change nothing. A snoop to the same index as the pending local request stalls that request for the cycle, so snoop handling always wins.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_ready`, `bus_req` and `snp_flush` are low.
- R2: A load that misses raises `bus_req` with `bus_op`=0 (read) and `bus_addr` equal to the request address. In the cycle after `bus_gnt`, `cpu_ready` pulses with `cpu_hit`=0 and `cpu_rdata` equal to the `bus_rdata` sampled at the grant. The line is installed Exclusive, so a later local store to it completes with no bus request.
- R3: A load that hits a Shared, Exclusive or Modified line raises no bus request. `cpu_ready` pulses in the cycle after the request is accepted, with `cpu_hit`=1 and the stored word.
- R4: A store that hits an Exclusive or Modified line raises no bus request, completes with `cpu_hit`=1 and leaves the line Modified, holding the new word.
- R5: A store that hits a Shared line raises `bus_op`=2 (invalidate) at the request address. After the grant it completes with `cpu_hit`=1 and leaves the line Modified.
- R6: A store that misses raises `bus_op`=1 (read for ownership). After the grant it completes with `cpu_hit`=0 and installs the line Modified, holding the store data.
- R7: A snooped read (`snp_op`=0) to a held line moves it to Shared. If the line is Modified, `snp_flush` is high in the snoop cycle and `snp_flush_data` carries the line's word.
- R8: A snooped read-for-ownership (`snp_op`=1) or invalidate (`snp_op`=2) to a held line moves it to Invalid. A Modified line flushes its word in the snoop cycle.
- R9: A snooped writeback (`snp_op`=3) leaves the line state unchanged and never raises `snp_flush`.
- R10: A miss whose index holds a Modified line first issues `bus_op`=3 (writeback). Its address is the victim's tag concatenated with the index, and `bus_wdata` carries the victim word. The fill follows after that grant. A clean victim is replaced with no writeback.
- R11: While a request waits for `bus_grant`, `bus_req` stays high and `cpu_ready` stays low. In a cycle where a snoop targets the pending request's index, `bus_req` is low and the request does not complete.
- R12: `cpu_ready` is a one-cycle pulse. The processor holds `cpu_valid` and its request fields until the pulse, then drops `cpu_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Request word address (low bits are the index) |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Request found its line valid, qualified by `cpu_ready` |
| cpu_rdata | output | DATA_W | Load data, qualified by `cpu_ready` |
| bus_req | output | 1 | Bus transaction requested |
| bus_op | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Fill data, valid with `bus_gnt` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_op | input | 2 | Snooped operation, same coding as `bus_op` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | Dirty data supplied in response to the snoop |
| snp_flush_data | output | DATA_W | Flushed word |

## Verification
A sweep brings one line into each of the four coherence states, then applies each of the four snooped operations, and then a local load or store. This separates downgrade from kill from no-op: whether the following access hits, upgrades or misses shows which state the snoop left behind. Tags step across a shared index, so fills land on Invalid, clean and dirty victims, which tells writeback-then-fill apart from a direct fill. Every bus request is held without a grant for a cycle. Two requests are overlapped with a snoop to their index, to show the stall on a miss and on a hit that would otherwise finish at once.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    OP_RD  = 2'd0,
    OP_RDX = 2'd1,
    OP_INV = 2'd2,
    OP_WB  = 2'd3
  } bus_op_t;

  // State a held line moves to when another cache's transaction hits it.
  function automatic line_st_t snoop_next(line_st_t st, bus_op_t op);
    line_st_t nxt;
    case (op)
      OP_RD:          nxt = (st == ST_I) ? ST_I : ST_S;
      OP_RDX, OP_INV: nxt = ST_I;
      default:        nxt = st;
    endcase
    return nxt;
  endfunction

  // Dirty data must leave the cache before a reader or a new owner proceeds.
  function automatic logic snoop_flushes(line_st_t st, bus_op_t op);
    return (st == ST_M) && (op != OP_WB);
  endfunction

  // A local store may complete without the bus only with sole ownership.
  function automatic logic owns_line(line_st_t st);
    return (st == ST_E) || (st == ST_M);
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // port a: local side, read and full-line write
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic              wa_en,
  input  line_st_t          wa_st,
  input  logic [TAG_W-1:0]  wa_tag,
  input  logic [DATA_W-1:0] wa_data,
  // port b: snoop side, read and state-only write
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              wb_en,
  input  line_st_t          wb_st,
  // all states, flattened two bits per line
  output logic [2*LINES-1:0] st_all
);

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [LINES-1:0]  wa_sel;
  logic [LINES-1:0]  wb_sel;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign wa_sel[g]        = wa_en && (a_idx == IDX_W'(g));
    assign wb_sel[g]        = wb_en && (b_idx == IDX_W'(g));
    assign st_all[2*g +: 2] = st_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= ST_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (wa_sel[i]) begin
          st_q[i]   <= wa_st;
          tag_q[i]  <= wa_tag;
          data_q[i] <= wa_data;
        end else if (wb_sel[i]) begin
          st_q[i]   <= wb_st;
        end
      end
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              snp_valid,
  input  bus_op_t           snp_op,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              snp_hit,
  output logic              wr_en,
  output line_st_t          wr_st,
  output logic              flush,
  output logic [DATA_W-1:0] flush_data
);

  assign snp_hit    = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
  assign wr_en      = snp_hit && (snp_op != OP_WB);
  assign wr_st      = snoop_next(line_st, snp_op);
  assign flush      = snp_hit && snoop_flushes(line_st, snp_op);
  assign flush_data = line_data;

endmodule

// File: rtl/coh_req_unit.sv
module coh_req_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              stall,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              loc_hit,
  output logic              bus_req,
  output bus_op_t           bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              done,
  output logic              done_hit,
  output logic [DATA_W-1:0] done_data,
  output logic              wr_en,
  output line_st_t          wr_st,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data
);

  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;

  assign req_idx = cpu_addr[IDX_W-1:0];
  assign req_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign loc_hit = (line_st != ST_I) && (line_tag == req_tag);

  // The action is decoded afresh every cycle from the line's current state,
  // so a snoop that changed the line while the request waited is honoured.
  always_comb begin
    bus_req   = 1'b0;
    bus_op    = OP_RD;
    bus_addr  = cpu_addr;
    bus_wdata = line_data;
    done      = 1'b0;
    done_hit  = loc_hit;
    done_data = cpu_write ? cpu_wdata : line_data;
    wr_en     = 1'b0;
    wr_st     = line_st;
    wr_tag    = line_tag;
    wr_data   = line_data;
    if (cpu_valid && !stall) begin
      if (loc_hit && (!cpu_write || owns_line(line_st))) begin
        done = 1'b1;
        if (cpu_write) begin
          wr_en   = 1'b1;
          wr_st   = ST_M;
          wr_data = cpu_wdata;
        end
      end else if (loc_hit) begin
        bus_req = 1'b1;
        bus_op  = OP_INV;
        if (bus_gnt) begin
          done    = 1'b1;
          wr_en   = 1'b1;
          wr_st   = ST_M;
          wr_data = cpu_wdata;
        end
      end else if (line_st == ST_M) begin
        bus_req  = 1'b1;
        bus_op   = OP_WB;
        bus_addr = {line_tag, req_idx};
        if (bus_gnt) begin
          wr_en = 1'b1;
          wr_st = ST_I;
        end
      end else begin
        bus_req = 1'b1;
        bus_op  = cpu_write ? OP_RDX : OP_RD;
        if (bus_gnt) begin
          done      = 1'b1;
          wr_en     = 1'b1;
          wr_tag    = req_tag;
          wr_st     = cpu_write ? ST_M : ST_E;
          wr_data   = cpu_write ? cpu_wdata : bus_rdata;
          done_data = cpu_write ? cpu_wdata : bus_rdata;
        end
      end
    end
  end

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_flush_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  // named internal events, also seen by the bound checker
  logic [IDX_W-1:0]  loc_idx;
  logic [IDX_W-1:0]  snp_idx;
  logic [TAG_W-1:0]  snp_tag;
  line_st_t          loc_st;
  logic [TAG_W-1:0]  loc_tag;
  logic [DATA_W-1:0] loc_data;
  line_st_t          s_st;
  logic [TAG_W-1:0]  s_tag;
  logic [DATA_W-1:0] s_data;
  logic [2*LINES-1:0] st_all;
  logic              snp_hit;
  logic              swr_en;
  line_st_t          swr_st;
  logic              snp_conflict;
  logic              stall;
  logic              loc_hit;
  logic              lwr_en;
  line_st_t          lwr_st;
  logic [TAG_W-1:0]  lwr_tag;
  logic [DATA_W-1:0] lwr_data;
  logic              done;
  logic              done_hit;
  logic [DATA_W-1:0] done_data;
  bus_op_t           req_op;
  logic              rsp_q;
  logic              hit_q;
  logic [DATA_W-1:0] rdata_q;

  assign loc_idx      = cpu_addr[IDX_W-1:0];
  assign snp_idx      = snp_addr[IDX_W-1:0];
  assign snp_tag      = snp_addr[ADDR_W-1:IDX_W];
  assign snp_conflict = snp_valid && (snp_idx == loc_idx);
  assign stall        = rsp_q || snp_conflict;

  coh_line_store #(
    .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_idx  (loc_idx),
    .a_st   (loc_st),
    .a_tag  (loc_tag),
    .a_data (loc_data),
    .wa_en  (lwr_en),
    .wa_st  (lwr_st),
    .wa_tag (lwr_tag),
    .wa_data(lwr_data),
    .b_idx  (snp_idx),
    .b_st   (s_st),
    .b_tag  (s_tag),
    .b_data (s_data),
    .wb_en  (swr_en),
    .wb_st  (swr_st),
    .st_all (st_all)
  );

  coh_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_op    (bus_op_t'(snp_op)),
    .snp_tag   (snp_tag),
    .line_st   (s_st),
    .line_tag  (s_tag),
    .line_data (s_data),
    .snp_hit   (snp_hit),
    .wr_en     (swr_en),
    .wr_st     (swr_st),
    .flush     (snp_flush),
    .flush_data(snp_flush_data)
  );

  coh_req_unit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_req (
    .cpu_valid(cpu_valid),
    .cpu_write(cpu_write),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .stall    (stall),
    .line_st  (loc_st),
    .line_tag (loc_tag),
    .line_data(loc_data),
    .bus_gnt  (bus_gnt),
    .bus_rdata(bus_rdata),
    .loc_hit  (loc_hit),
    .bus_req  (bus_req),
    .bus_op   (req_op),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .done     (done),
    .done_hit (done_hit),
    .done_data(done_data),
    .wr_en    (lwr_en),
    .wr_st    (lwr_st),
    .wr_tag   (lwr_tag),
    .wr_data  (lwr_data)
  );

  assign bus_op = req_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      hit_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= done;
      if (done) begin
        hit_q   <= done_hit;
        rdata_q <= done_data;
      end
    end
  end

  assign cpu_ready = rsp_q;
  assign cpu_hit   = hit_q;
  assign cpu_rdata = rdata_q;

endmodule

// File: rtl/coh_ctrl_checker.sv
module coh_ctrl_checker #(
  parameter int LINES = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_valid,
  input logic             cpu_ready,
  input logic             bus_req,
  input logic [1:0]       bus_op,
  input logic             snp_valid,
  input logic [1:0]       snp_op,
  input logic             snp_hit,
  input logic             snp_flush,
  input logic [IDX_W-1:0] snp_idx,
  input logic [IDX_W-1:0] loc_idx,
  input logic [1:0]       loc_st,
  input logic [1:0]       s_st,
  input logic [2*LINES-1:0] st_all,
  input logic             lwr_en,
  input logic             swr_en
);

  logic [IDX_W-1:0] snp_idx_q;
  logic [1:0]       st_prev_snp;

  always_ff @(posedge clk) snp_idx_q <= snp_idx;

  always_comb begin
    st_prev_snp = 2'd0;
    for (int i = 0; i < LINES; i++)
      if (i[IDX_W-1:0] == snp_idx_q) st_prev_snp = st_all[2*i +: 2];
  end

  p_rd_snoop_shares_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_hit && snp_op == 2'd0) |=> (st_prev_snp == 2'd1));

  p_flush_leaves_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |=> (st_prev_snp != 2'd3));

  p_kill_snoop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_hit && (snp_op == 2'd1 || snp_op == 2'd2)) |=> (st_prev_snp == 2'd0));

  p_wb_snoop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == 2'd3) |=> (st_prev_snp == $past(s_st)));

  p_wb_snoop_no_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == 2'd3) |-> !snp_flush);

  p_no_fill_over_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && (bus_op == 2'd0 || bus_op == 2'd1)) |-> (loc_st != 2'd3));

  p_snoop_stalls_local_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && snp_valid && snp_idx == loc_idx) |-> !bus_req);

  p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);

  p_no_req_while_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !bus_req);

  always_comb begin
    if (rst_n) begin
      p_single_writer_r11: assert (!(lwr_en && swr_en && snp_idx == loc_idx));
    end
  end

endmodule

bind snoop_coh_ctrl coh_ctrl_checker #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_valid  (cpu_valid),
  .cpu_ready  (cpu_ready),
  .bus_req    (bus_req),
  .bus_op     (bus_op),
  .snp_valid  (snp_valid),
  .snp_op     (snp_op),
  .snp_hit    (snp_hit),
  .snp_flush  (snp_flush),
  .snp_idx    (snp_idx),
  .loc_idx    (loc_idx),
  .loc_st     (loc_st),
  .s_st       (s_st),
  .st_all     (st_all),
  .lwr_en     (lwr_en),
  .swr_en     (swr_en)
);

// File: tb/tb_snoop_coh_ctrl.sv
module tb_snoop_coh_ctrl;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int LINES  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_valid = 1'b0;
  logic              cpu_write = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_ready;
  logic              cpu_hit;
  logic [DATA_W-1:0] cpu_rdata;
  logic              bus_req;
  logic [1:0]        bus_op;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_gnt = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              snp_valid = 1'b0;
  logic [1:0]        snp_op = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic              snp_flush;
  logic [DATA_W-1:0] snp_flush_data;

  int checks = 0;
  int failures = 0;

  // reference model: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified
  int                m_st   [LINES];
  logic [5:0]        m_tag  [LINES];
  logic [DATA_W-1:0] m_data [LINES];

  always #2.5 clk = ~clk;

  snoop_coh_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
    .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_gnt(bus_gnt),
    .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_op(snp_op),
    .snp_addr(snp_addr), .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
  );

  function automatic logic [DATA_W-1:0] memval(logic [ADDR_W-1:0] a);
    return a * 8'd7 + 8'd3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic access(input logic w, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input bit cf);
    int idx;
    logic [5:0] tg;
    bit hitm;
    int op;
    logic [ADDR_W-1:0] ea;
    string tag;
    idx = int'(a[1:0]);
    tg  = a[7:2];
    cpu_write = w; cpu_addr = a; cpu_wdata = d; cpu_valid = 1'b1;
    if (cf) begin
      snp_valid = 1'b1; snp_op = 2'd3; snp_addr = {~tg, a[1:0]};
      #1;
      chk(bus_req == 1'b0, "R11 snoop on same index blocks bus_req", int'(bus_req), 0);
      next();
      chk(cpu_ready == 1'b0, "R11 snoop on same index blocks completion", int'(cpu_ready), 0);
      snp_valid = 1'b0;
    end
    #1;
    for (int step = 0; step < 3; step++) begin
      hitm = (m_st[idx] != 0) && (m_tag[idx] == tg);
      if (hitm && (!w || m_st[idx] >= 2)) begin
        tag = w ? "R4 owned store hit" : "R3 load hit";
        chk(bus_req == 1'b0, tag, int'(bus_req), 0);
        next();
        chk(cpu_ready == 1'b1, tag, int'(cpu_ready), 1);
        chk(cpu_hit == 1'b1, tag, int'(cpu_hit), 1);
        chk(cpu_rdata == (w ? d : m_data[idx]), tag, int'(cpu_rdata), int'(w ? d : m_data[idx]));
        if (w) begin m_st[idx] = 3; m_data[idx] = d; end
        break;
      end
      if (!hitm && m_st[idx] == 3) begin op = 3; ea = {m_tag[idx], a[1:0]}; tag = "R10 dirty victim writeback"; end
      else if (hitm) begin op = 2; ea = a; tag = "R5 shared store upgrade"; end
      else begin op = w ? 1 : 0; ea = a; tag = w ? "R6 store miss" : "R2 load miss"; end
      chk(bus_req == 1'b1, tag, int'(bus_req), 1);
      chk(int'(bus_op) == op, tag, int'(bus_op), op);
      chk(bus_addr == ea, tag, int'(bus_addr), int'(ea));
      if (op == 3) chk(bus_wdata == m_data[idx], tag, int'(bus_wdata), int'(m_data[idx]));
      next();
      chk(bus_req == 1'b1 && cpu_ready == 1'b0, "R11 hold without grant",
          int'({bus_req, cpu_ready}), 2);
      bus_gnt = 1'b1; bus_rdata = memval(a);
      next();
      bus_gnt = 1'b0;
      if (op == 3) begin
        m_st[idx] = 0;
        continue;
      end
      chk(cpu_ready == 1'b1, tag, int'(cpu_ready), 1);
      chk(cpu_hit == (op == 2), tag, int'(cpu_hit), int'(op == 2));
      chk(cpu_rdata == (w ? d : memval(a)), tag, int'(cpu_rdata), int'(w ? d : memval(a)));
      chk(bus_req == 1'b0, "R12 no request during ready", int'(bus_req), 0);
      case (op)
        2: begin m_st[idx] = 3; m_data[idx] = d; end
        1: begin m_st[idx] = 3; m_tag[idx] = tg; m_data[idx] = d; end
        default: begin m_st[idx] = 2; m_tag[idx] = tg; m_data[idx] = memval(a); end
      endcase
      break;
    end
    cpu_valid = 1'b0;
    next();
    chk(cpu_ready == 1'b0, "R12 ready is one cycle", int'(cpu_ready), 0);
  endtask

  task automatic snoop(input logic [1:0] op, input logic [ADDR_W-1:0] a);
    int idx;
    bit hitm;
    bit expf;
    string tag;
    idx  = int'(a[1:0]);
    hitm = (m_st[idx] != 0) && (m_tag[idx] == a[7:2]);
    tag  = (op == 2'd0) ? "R7 snooped read" : (op == 2'd3) ? "R9 snooped writeback" : "R8 snooped kill";
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    #1;
    expf = hitm && m_st[idx] == 3 && op != 2'd3;
    chk(snp_flush == expf, tag, int'(snp_flush), int'(expf));
    if (expf) chk(snp_flush_data == m_data[idx], tag, int'(snp_flush_data), int'(m_data[idx]));
    next();
    snp_valid = 1'b0;
    if (hitm) begin
      if (op == 2'd0) m_st[idx] = 1;
      else if (op != 2'd3) m_st[idx] = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cpu_ready == 1'b0, "R1 reset ready low", int'(cpu_ready), 0);
    chk(bus_req == 1'b0, "R1 reset no bus request", int'(bus_req), 0);
    chk(snp_flush == 1'b0, "R1 reset no flush", int'(snp_flush), 0);
    // R1: every index misses right after reset
    for (int i = 0; i < LINES; i++) snoop(2'd0, {6'h2A, i[1:0]});
    for (int i = 0; i < LINES; i++) access(1'b0, {6'h3F, i[1:0]}, 8'h00, 1'b0);

    // sweep: start state x snooped operation x following access
    for (int k = 0; k < 16; k++) begin
      logic [ADDR_W-1:0] a;
      int s;
      int sop;
      s   = k / 4;
      sop = k % 4;
      a   = {6'(k + 1), 2'((k / 2) % 4)};
      case (s)
        0: begin access(1'b0, a, 8'h00, 1'b0); snoop(2'd2, a); end
        1: begin access(1'b0, a, 8'h00, 1'b0); snoop(2'd0, a); end
        2: access(1'b0, a, 8'h00, 1'b0);
        default: access(1'b1, a, 8'(k * 17 + 1), 1'b0);
      endcase
      snoop(2'(sop), a);
      snoop(2'(sop), {6'(k + 40), a[1:0]});
      access(1'(k % 2), a, 8'(k * 29 + 5), (k == 5) || (k == 11));
      access(1'b0, a, 8'h00, 1'b0);
      snoop(2'd0, a);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule